// File: doc/BRIEF.md
# Accumulator Word and Halfword Extract Unit

This unit reads one of four 64-bit signed accumulators and returns a 32-bit value taken from it after an arithmetic right shift. Each accumulator reaches the unit as a high and a low 32-bit half on wide input buses. The shift distance comes either from an immediate field or from the low bits of a general register, chosen per operation. Four operation kinds are offered: a plain truncating word extract, a rounded word extract, a rounded word extract that saturates, and a halfword extract that saturates to 16 signed bits and sign-extends to 32.

Whenever the shifted value does not fit the destination width, the unit sets a sticky overflow flag. The flag stays set until the surrounding control logic clears it with an explicit clear strobe. A start strobe launches an operation. The result and a done strobe appear one clock edge later, and the result holds until the next start. Writing the accumulators themselves is handled elsewhere.

Top module: `acc_extract_unit`

## Requirements
- R1: After reset, `result_o` is 0, `done_o` is 0 and `ovf_flag_o` is 0.
- R2: The operand is the 64-bit value {HI, LO}, with LO taken as unsigned. Accumulator k occupies bits [32k+31:32k] of both `acc_hi_i` and `acc_lo_i` and is chosen by `acc_sel_i` = k (k = 0 to 3).
- R3: The shift amount is the low 5 bits of `shift_imm_i` when `shift_src_i` = 0 and is `shift_gpr_i` when `shift_src_i` = 1. Legal shifts run from 0 to 31.
- R4: `op_i` = 0 (truncate) returns the low 32 bits of the arithmetically shifted operand. It sets the flag when that value lies outside the signed 32-bit range, and the returned bits are unchanged in that case.
- R5: `op_i` = 1 (round) adds 2^(s-1) to the operand before shifting when s > 0, using 65-bit precision so that the addition cannot wrap. It returns the low 32 bits and flags overflow as in R4.
- R6: `op_i` = 2 (round and saturate) rounds as in R5. When the result is out of range it returns 0x7FFFFFFF for a positive value or 0x80000000 for a negative value, and it sets the flag.
- R7: `op_i` = 3 (halfword) shifts without rounding. A value above 32767 gives 0x00007FFF, a value below -32768 gives 0xFFFF8000, and each clamp sets the flag. Any other value is returned sign-extended.
- R8: The flag is sticky. Only `flag_clr_i` clears it. If a clear and an overflowing extract fall in the same cycle, the flag ends set.
- R9: `result_o` and `done_o` update on the clock edge that samples `start_i`. `done_o` is high for exactly that one cycle, and `result_o` holds its value while `start_i` is low.
- R10: With HI=0x3FFFFFFF, LO=0x2BCDEF01 and shift 31, operations 0, 1 and 2 each return 0x7FFFFFFE with no overflow. With HI=0x00000123, LO=0x87654321 and shift 28, operation 3 returns 0x00001238 with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch one extract |
| op_i | input | 2 | Operation: 0 truncate, 1 round, 2 round+saturate, 3 halfword saturate |
| acc_sel_i | input | 2 | Accumulator index |
| shift_src_i | input | 1 | 0 selects the immediate shift, 1 selects the register shift |
| shift_imm_i | input | 5 | Immediate shift amount |
| shift_gpr_i | input | 5 | Low bits of the general register holding the shift |
| acc_hi_i | input | 128 | High halves of the four accumulators |
| acc_lo_i | input | 128 | Low halves of the four accumulators |
| flag_clr_i | input | 1 | Explicit clear of the overflow flag |
| result_o | output | 32 | Extracted result |
| done_o | output | 1 | One-cycle completion strobe |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The overflow-setting path of an extract and the explicit flag clear can land on the same clock edge. The bench provokes this both in directed steps and by random clears that coincide with overflowing and non-overflowing extracts. A bench model predicts the flag as (old AND NOT clear) OR overflow, and the bench compares `ovf_flag_o` against that model after every operation and after every clear issued on its own.

// File: rtl/acc_extract_pkg.sv
package acc_extract_pkg;
  typedef enum logic [1:0] {
    XOP_TRUNC  = 2'd0,
    XOP_RND    = 2'd1,
    XOP_RNDSAT = 2'd2,
    XOP_HSAT   = 2'd3
  } xop_e;
endpackage

// File: rtl/acc_slot_mux.sv
module acc_slot_mux #(
  parameter int DW   = 32,
  parameter int NACC = 4,
  localparam int SW  = $clog2(NACC)
) (
  input  logic [NACC*DW-1:0] hi_bus_i,
  input  logic [NACC*DW-1:0] lo_bus_i,
  input  logic [SW-1:0]      sel_i,
  output logic [2*DW-1:0]    acc_o
);
  logic [2*DW-1:0] slot [NACC];

  for (genvar k = 0; k < NACC; k++) begin : g_slot
    assign slot[k] = {hi_bus_i[k*DW +: DW], lo_bus_i[k*DW +: DW]};
  end

  assign acc_o = slot[sel_i];
endmodule

// File: rtl/shift_pick.sv
module shift_pick #(
  parameter int SHW = 5
) (
  input  logic           src_i,
  input  logic [SHW-1:0] imm_i,
  input  logic [SHW-1:0] gpr_i,
  output logic [SHW-1:0] amt_o
);
  always_comb begin
    amt_o = src_i ? gpr_i : imm_i;
  end
endmodule

// File: rtl/extract_core.sv
module extract_core
  import acc_extract_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SHW = 5,
  localparam int WW = 2*DW + 1,
  localparam int HW = DW/2
) (
  input  logic [2*DW-1:0] acc_i,
  input  logic [SHW-1:0]  amt_i,
  input  xop_e            op_i,
  output logic [DW-1:0]   res_o,
  output logic            ovf_o
);
  logic [WW-1:0]        wide;
  logic [WW-1:0]        bias;
  logic signed [WW-1:0] sum_s;
  logic [WW-1:0]        shifted;
  logic                 word_fits;
  logic                 half_fits;
  logic                 use_rnd;
  logic [WW-DW:0]       word_top;
  logic [WW-HW:0]       half_top;

  always_comb begin
    wide    = {acc_i[2*DW-1], acc_i};
    use_rnd = (op_i == XOP_RND) || (op_i == XOP_RNDSAT);
    bias    = '0;
    if (use_rnd && (amt_i != '0)) begin
      bias = {{(WW-1){1'b0}}, 1'b1} << (amt_i - 1'b1);
    end
    sum_s   = $signed(wide + bias);
    shifted = sum_s >>> amt_i;
  end

  always_comb begin
    word_top  = shifted[WW-1:DW-1];
    half_top  = shifted[WW-1:HW-1];
    word_fits = (&word_top) || (~|word_top);
    half_fits = (&half_top) || (~|half_top);
  end

  always_comb begin
    res_o = shifted[DW-1:0];
    ovf_o = 1'b0;
    unique case (op_i)
      XOP_TRUNC, XOP_RND: begin
        ovf_o = ~word_fits;
      end
      XOP_RNDSAT: begin
        ovf_o = ~word_fits;
        if (!word_fits) begin
          res_o = shifted[WW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        end
      end
      XOP_HSAT: begin
        ovf_o = ~half_fits;
        if (!half_fits) begin
          res_o = shifted[WW-1] ? {{(HW+1){1'b1}}, {(HW-1){1'b0}}}
                                : {{(HW+1){1'b0}}, {(HW-1){1'b1}}};
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_extract_unit.sv
module acc_extract_unit
  import acc_extract_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NACC = 4,
  parameter int SHW  = 5,
  localparam int SW  = $clog2(NACC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [SW-1:0]     acc_sel_i,
  input  logic              shift_src_i,
  input  logic [SHW-1:0]    shift_imm_i,
  input  logic [SHW-1:0]    shift_gpr_i,
  input  logic [NACC*DW-1:0] acc_hi_i,
  input  logic [NACC*DW-1:0] acc_lo_i,
  input  logic              flag_clr_i,
  output logic [DW-1:0]     result_o,
  output logic              done_o,
  output logic              ovf_flag_o
);
  logic [2*DW-1:0] acc_sel;
  logic [SHW-1:0]  amt;
  logic [DW-1:0]   core_res;
  logic            core_ovf;
  logic [DW-1:0]   res_d, res_q;
  logic            done_d, done_q;
  logic            flag_d, flag_q;

  acc_slot_mux #(.DW(DW), .NACC(NACC)) u_mux (
    .hi_bus_i(acc_hi_i), .lo_bus_i(acc_lo_i), .sel_i(acc_sel_i), .acc_o(acc_sel)
  );

  shift_pick #(.SHW(SHW)) u_amt (
    .src_i(shift_src_i), .imm_i(shift_imm_i), .gpr_i(shift_gpr_i), .amt_o(amt)
  );

  extract_core #(.DW(DW), .SHW(SHW)) u_core (
    .acc_i(acc_sel), .amt_i(amt), .op_i(xop_e'(op_i)), .res_o(core_res), .ovf_o(core_ovf)
  );

  always_comb begin
    res_d  = res_q;
    done_d = start_i;
    flag_d = flag_q & ~flag_clr_i;
    if (start_i) begin
      res_d  = core_res;
      flag_d = flag_d | core_ovf;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      done_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      done_q <= done_d;
      flag_q <= flag_d;
      if (start_i) begin
        res_q <= res_d;
      end
    end
  end

  assign result_o   = res_q;
  assign done_o     = done_q;
  assign ovf_flag_o = flag_q;

  // R9
  done_follows_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  // R9
  done_needs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o));
  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !flag_clr_i) |=> ovf_flag_o);
  // R8
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_o) |-> done_o);
endmodule

// File: tb/sim_acc_extract_unit.sv
`timescale 1ns/1ps
module sim_acc_extract_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         start_i;
  logic [1:0]   op_i;
  logic [1:0]   acc_sel_i;
  logic         shift_src_i;
  logic [4:0]   shift_imm_i;
  logic [4:0]   shift_gpr_i;
  logic [127:0] acc_hi_i;
  logic [127:0] acc_lo_i;
  logic         flag_clr_i;
  logic [31:0]  result_o;
  logic         done_o;
  logic         ovf_flag_o;

  int total = 0;
  int bad   = 0;
  logic        flag_m;
  logic [31:0] res_m;

  always #2 clk_i = ~clk_i;

  acc_extract_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .acc_sel_i(acc_sel_i), .shift_src_i(shift_src_i), .shift_imm_i(shift_imm_i),
    .shift_gpr_i(shift_gpr_i), .acc_hi_i(acc_hi_i), .acc_lo_i(acc_lo_i),
    .flag_clr_i(flag_clr_i), .result_o(result_o), .done_o(done_o),
    .ovf_flag_o(ovf_flag_o)
  );

  function automatic void model(input logic [63:0] a, input logic [4:0] s,
                                input logic [1:0] op, output logic [31:0] r,
                                output logic o);
    logic signed [64:0] v;
    v = $signed({a[63], a});
    if ((op == 2'd1 || op == 2'd2) && s != 0) v = v + (65'sd1 <<< (s - 1));
    v = v >>> s;
    r = v[31:0];
    o = 1'b0;
    if (op == 2'd3) begin
      if (v > 65'sd32767)       begin r = 32'h0000_7FFF; o = 1'b1; end
      else if (v < -65'sd32768) begin r = 32'hFFFF_8000; o = 1'b1; end
    end else begin
      if (v > 65'sd2147483647)       o = 1'b1;
      else if (v < -65'sd2147483648) o = 1'b1;
      if (o && op == 2'd2) r = v[64] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    end
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic set_acc(input int k, input logic [31:0] hi, input logic [31:0] lo);
    acc_hi_i[k*32 +: 32] = hi;
    acc_lo_i[k*32 +: 32] = lo;
  endtask

  // issue at a negedge, check at the following negedge
  task automatic run_op(input string tag, input logic [1:0] op, input logic [1:0] sel,
                        input logic src, input logic [4:0] imm, input logic [4:0] gpr,
                        input logic clr);
    logic [31:0] r;
    logic        o;
    model({acc_hi_i[sel*32 +: 32], acc_lo_i[sel*32 +: 32]}, src ? gpr : imm, op, r, o);
    op_i = op; acc_sel_i = sel; shift_src_i = src; shift_imm_i = imm; shift_gpr_i = gpr;
    flag_clr_i = clr; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; flag_clr_i = 1'b0;
    flag_m = (flag_m & ~clr) | o;
    res_m  = r;
    chk({tag, " result"}, result_o, res_m);
    chk({tag, " flag"}, {31'd0, ovf_flag_o}, {31'd0, flag_m});
    chk({tag, " done"}, {31'd0, done_o}, 32'd1);
  endtask

  task automatic clear_only(input string tag);
    flag_clr_i = 1'b1;
    @(negedge clk_i);
    flag_clr_i = 1'b0;
    flag_m = 1'b0;
    chk({tag, " flag"}, {31'd0, ovf_flag_o}, 32'd0);
    chk({tag, " result held"}, result_o, res_m);
    chk({tag, " no done"}, {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_ni = 1'b0; start_i = 1'b0; op_i = '0; acc_sel_i = '0; shift_src_i = 1'b0;
    shift_imm_i = '0; shift_gpr_i = '0; flag_clr_i = 1'b0;
    acc_hi_i = '0; acc_lo_i = '0;
    flag_m = 1'b0; res_m = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 result", result_o, 32'd0);
    chk("R1 done", {31'd0, done_o}, 32'd0);
    chk("R1 flag", {31'd0, ovf_flag_o}, 32'd0);

    // R10 given vectors in slot 1, immediate and register shift
    set_acc(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    set_acc(1, 32'h3FFF_FFFF, 32'h2BCD_EF01);
    set_acc(2, 32'h0000_0123, 32'h8765_4321);
    set_acc(3, 32'h4000_0000, 32'h0000_0000);
    run_op("R10 trunc imm31", 2'd0, 2'd1, 1'b0, 5'd31, 5'd0, 1'b0);
    chk("R10 trunc value", result_o, 32'h7FFF_FFFE);
    run_op("R10 round gpr31", 2'd1, 2'd1, 1'b1, 5'd3, 5'd31, 1'b0);
    chk("R10 round value", result_o, 32'h7FFF_FFFE);
    run_op("R10 rsat gpr31", 2'd2, 2'd1, 1'b1, 5'd0, 5'd31, 1'b0);
    chk("R10 rsat value", result_o, 32'h7FFF_FFFE);
    run_op("R10 half gpr28", 2'd3, 2'd2, 1'b1, 5'd0, 5'd28, 1'b0);
    chk("R10 half value", result_o, 32'h0000_1238);

    // R2 slot select and LO unsigned: slot 0 = -1, shift 0 -> 0xFFFFFFFF no ovf
    run_op("R2 slot0", 2'd0, 2'd0, 1'b0, 5'd0, 5'd0, 1'b0);
    chk("R2 slot0 value", result_o, 32'hFFFF_FFFF);
    // R4 truncate overflow keeps low bits, sets flag
    run_op("R4 trunc ovf", 2'd0, 2'd3, 1'b0, 5'd0, 5'd0, 1'b0);
    chk("R4 low bits", result_o, 32'h0000_0000);
    chk("R4 flag set", {31'd0, ovf_flag_o}, 32'd1);
    // R8 sticky across a fitting extract
    run_op("R8 sticky", 2'd0, 2'd1, 1'b0, 5'd31, 5'd0, 1'b0);
    chk("R8 still set", {31'd0, ovf_flag_o}, 32'd1);
    clear_only("R8 clear");
    // R8 clear and overflow same cycle
    run_op("R8 clr+ovf", 2'd0, 2'd3, 1'b0, 5'd0, 5'd0, 1'b1);
    chk("R8 set wins", {31'd0, ovf_flag_o}, 32'd1);
    run_op("R8 clr+fit", 2'd3, 2'd2, 1'b0, 5'd28, 5'd0, 1'b1);
    chk("R8 cleared", {31'd0, ovf_flag_o}, 32'd0);

    // R5 rounding
    set_acc(0, 32'h0000_0000, 32'h0000_000B);
    run_op("R5 round", 2'd1, 2'd0, 1'b0, 5'd2, 5'd0, 1'b0);
    chk("R5 value", result_o, 32'd3);
    run_op("R4 trunc no round", 2'd0, 2'd0, 1'b0, 5'd2, 5'd0, 1'b0);
    chk("R4 value", result_o, 32'd2);
    // R5/R6 carry into top bit
    set_acc(0, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    clear_only("R5 pre clear");
    run_op("R5 wide carry", 2'd1, 2'd0, 1'b0, 5'd1, 5'd0, 1'b0);
    chk("R5 wide value", result_o, 32'h0000_0000);
    run_op("R6 pos sat", 2'd2, 2'd0, 1'b0, 5'd1, 5'd0, 1'b0);
    chk("R6 pos value", result_o, 32'h7FFF_FFFF);
    set_acc(0, 32'h8000_0000, 32'h0000_0000);
    run_op("R6 neg sat", 2'd2, 2'd0, 1'b0, 5'd4, 5'd0, 1'b0);
    chk("R6 neg value", result_o, 32'h8000_0000);
    // R7 halfword clamps
    set_acc(0, 32'hFFFF_FFFF, 32'h8000_0000);
    clear_only("R7 pre clear");
    run_op("R7 neg clamp", 2'd3, 2'd0, 1'b0, 5'd0, 5'd0, 1'b0);
    chk("R7 neg value", result_o, 32'hFFFF_8000);
    set_acc(0, 32'hFFFF_FFFF, 32'hFFFF_8000);
    clear_only("R7 clear2");
    run_op("R7 min fits", 2'd3, 2'd0, 1'b0, 5'd0, 5'd0, 1'b0);
    chk("R7 min value", result_o, 32'hFFFF_8000);
    chk("R7 min no flag", {31'd0, ovf_flag_o}, 32'd0);
    // R3 register shift ignored when immediate selected
    set_acc(0, 32'h0000_0000, 32'h0000_0100);
    run_op("R3 imm used", 2'd0, 2'd0, 1'b0, 5'd4, 5'd8, 1'b0);
    chk("R3 imm value", result_o, 32'h10);
    run_op("R3 gpr used", 2'd0, 2'd0, 1'b1, 5'd4, 5'd8, 1'b0);
    chk("R3 gpr value", result_o, 32'h1);

    // random mix (R2..R9)
    for (int n = 0; n < 600; n++) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] h;
        h = $urandom;
        h = $signed(h) >>> ($urandom % 32);
        set_acc(k, h, $urandom);
      end
      if ($urandom % 8 == 0) clear_only("R8 rnd clear");
      run_op("R9 rnd", 2'($urandom), 2'($urandom), 1'($urandom), 5'($urandom),
             5'($urandom), ($urandom % 6) == 0);
      if ($urandom % 4 == 0) begin
        @(negedge clk_i);
        chk("R9 hold", result_o, res_m);
        chk("R9 done low", {31'd0, done_o}, 32'd0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule